// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This block is the hazard controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) in which conditional branches compare their operands and resolve in decode. Each cycle it reads a description of every in-flight instruction: the source register numbers with their use flags, the destination register number, the write-enable flag and the load flag. It also reads the branch outcome that the decode comparator produced. The datapath, register file and memories stay outside the block.

From these inputs it produces four things. The first is the operand-source selects for the two execute-stage ALU inputs. The second is a pair of selects that steer the result held at the start of the memory stage into the decode comparator. The third is a single stall condition, fanned out to hold the fetch and decode registers and to turn the execute-stage slot into a bubble. The fourth is a flush that kills the sequentially fetched instruction behind a taken branch; branches are predicted not-taken and there is no delay slot.

Every output is combinational in the current stage contents. A multi-cycle stall therefore comes from the pipeline moving its producer forward one stage per cycle while the consumer waits.

Top module: `hazard_unit`

## Requirements
- R1: An ALU source that is in use in execute selects code 2 (memory-stage result) when the memory-stage instruction writes that register.
- R2: Otherwise the source selects code 1 (writeback-stage result) when the writeback instruction writes that register, and code 0 (register file) when no stage matches. When both stages match, code 2 wins.
- R3: Register 0 never causes forwarding, a stall or a lost flush.
- R4: When a decode-stage source in use matches the destination of a load in execute, `stall_fetch`, `stall_decode` and `bubble_ex` are all 1 in that cycle.
- R5: When a branch in decode reads a register written by a non-load instruction in execute, the stall is asserted for that cycle.
- R6: When a branch in decode reads a register written by a load, the stall is asserted while the load is in execute and again while it is in memory. This gives two cycles in total.
- R7: When a branch source matches a non-load writer in the memory stage, the decode select for that source is 1 (take the memory-stage result) and no stall is raised. A load in memory never drives this select.
- R8: A writer in writeback causes neither a decode select nor a stall, because the register file writes before it is read.
- R9: `flush_fetch` is 1 exactly when decode holds a branch whose condition is taken and no stall is asserted. A stall suppresses the flush.
- R10: A non-branch decode instruction that reads the result of a non-load in execute does not stall.
- R11: A source whose use flag is 0 never causes a forward or a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_taken | input | 1 | Branch condition computed in decode is true |
| ex_rs | input | AW | First source register of the execute instruction |
| ex_rt | input | AW | Second source register of the execute instruction |
| ex_use_rs | input | 1 | Execute instruction reads ex_rs |
| ex_use_rt | input | 1 | Execute instruction reads ex_rt |
| ex_rd | input | AW | Destination of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | AW | Destination of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| ex_sel_a | output | 2 | Source select for ALU input A (0 file, 1 writeback, 2 memory stage) |
| ex_sel_b | output | 2 | Source select for ALU input B (same coding) |
| id_sel_a | output | 1 | Comparator input A takes the memory-stage result |
| id_sel_b | output | 1 | Comparator input B takes the memory-stage result |
| stall_fetch | output | 1 | Hold the fetch register |
| stall_decode | output | 1 | Hold the decode register |
| bubble_ex | output | 1 | Load a bubble into execute |
| flush_fetch | output | 1 | Kill the instruction fetched behind a taken branch |

## Verification
The directed patterns separate the producer/consumer distances that need different responses:
- an ALU producer one stage ahead of an ALU consumer, which forwards without a stall;
- an ALU producer one stage ahead of a branch, which stalls once and then forwards to the comparator;
- a load ahead of a branch, walked through execute, memory and writeback, which shows two stall cycles followed by a clean register-file read;
- a load ahead of an ALU consumer, which stalls once.

Cases with both late stages matching show that the younger result is chosen. Cases with register 0 and with cleared use flags show that neither starts a forward or a stall. A taken branch is applied both during a stall and after it, which shows that the flush waits for the operands. A long run of random stage contents, drawn from only four register numbers so that collisions are frequent, mixes all of these situations and compares every output with an independent model.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
  // Widest register number the helper functions accept; modules zero-extend.
  localparam int unsigned RID_MAX = 8;
  typedef logic [RID_MAX-1:0] rid_t;

  // Operand source for an execute-stage ALU input.
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_WB  = 2'd1,
    SRC_MEM = 2'd2
  } ex_src_e;

  // A live source depends on a writer when both name the same non-zero register.
  function automatic logic rd_hit(input rid_t src, input logic used,
                                  input rid_t dst, input logic wen);
    return used && wen && (src != '0) && (src == dst);
  endfunction

  // The younger producer wins over the older one.
  function automatic ex_src_e ex_pick(input logic mem_hit, input logic wb_hit);
    if (mem_hit) return SRC_MEM;
    if (wb_hit)  return SRC_WB;
    return SRC_RF;
  endfunction

  // Taken-branch redirect only once the operands are valid.
  function automatic logic redirect(input logic branch, input logic taken,
                                    input logic hold);
    return branch && taken && !hold;
  endfunction
endpackage

// File: rtl/hzu_ex_pick.sv
module hzu_ex_pick #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    sel
);
  import hzu_pkg::*;

  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = rd_hit(rid_t'(src), used, rid_t'(mem_rd), mem_wen);
    wb_hit  = rd_hit(rid_t'(src), used, rid_t'(wb_rd), wb_wen);
    sel     = ex_pick(mem_hit, wb_hit);
  end
endmodule

// File: rtl/hzu_id_pick.sv
module hzu_id_pick #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  output logic          from_mem
);
  import hzu_pkg::*;

  // Load data is not present at the start of memory, so only ALU results feed the comparator.
  always_comb begin
    from_mem = rd_hit(rid_t'(src), used, rid_t'(mem_rd), mem_wen) && !mem_load;
  end
endmodule

// File: rtl/hzu_stall_ctrl.sv
module hzu_stall_ctrl #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src,
  input  logic [NSRC-1:0]         used,
  input  logic                    id_branch,
  input  logic                    id_taken,
  input  logic [AW-1:0]           ex_rd,
  input  logic                    ex_wen,
  input  logic                    ex_load,
  input  logic [AW-1:0]           mem_rd,
  input  logic                    mem_wen,
  input  logic                    mem_load,
  output logic                    load_use,
  output logic                    br_wait,
  output logic                    stall,
  output logic                    flush
);
  import hzu_pkg::*;

  logic [NSRC-1:0] lu_vec;
  logic [NSRC-1:0] bw_vec;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic ex_dep;
    logic mem_ld_dep;
    always_comb begin
      ex_dep     = rd_hit(rid_t'(src[k]), used[k], rid_t'(ex_rd), ex_wen);
      mem_ld_dep = rd_hit(rid_t'(src[k]), used[k], rid_t'(mem_rd), mem_wen) && mem_load;
      lu_vec[k]  = ex_dep && ex_load;
      bw_vec[k]  = id_branch && (ex_dep || mem_ld_dep);
    end
  end

  always_comb begin
    load_use = |lu_vec;
    br_wait  = |bw_vec;
    stall    = load_use || br_wait;
    flush    = redirect(id_branch, id_taken, stall);
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_branch,
  input  logic          id_taken,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic          ex_use_rs,
  input  logic          ex_use_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic          id_sel_a,
  output logic          id_sel_b,
  output logic          stall_fetch,
  output logic          stall_decode,
  output logic          bubble_ex,
  output logic          flush_fetch
);
  localparam int unsigned NOPS = 2;

  logic [NOPS-1:0][AW-1:0] id_src;
  logic [NOPS-1:0]         id_use;
  logic [NOPS-1:0][AW-1:0] ex_src;
  logic [NOPS-1:0]         ex_use;
  logic [NOPS-1:0][1:0]    ex_sel_v;
  logic [NOPS-1:0]         id_sel_v;

  // Named internal events for the checker.
  logic load_use_evt;
  logic br_wait_evt;
  logic stall_evt;
  logic flush_evt;

  assign id_src = {id_rt, id_rs};
  assign id_use = {id_use_rt, id_use_rs};
  assign ex_src = {ex_rt, ex_rs};
  assign ex_use = {ex_use_rt, ex_use_rs};

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    hzu_ex_pick #(.AW(AW)) u_ex_pick (
      .src     (ex_src[k]),
      .used    (ex_use[k]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (ex_sel_v[k])
    );
    hzu_id_pick #(.AW(AW)) u_id_pick (
      .src      (id_src[k]),
      .used     (id_use[k]),
      .mem_rd   (mem_rd),
      .mem_wen  (mem_wen),
      .mem_load (mem_load),
      .from_mem (id_sel_v[k])
    );
  end

  hzu_stall_ctrl #(.AW(AW), .NSRC(NOPS)) u_stall (
    .src       (id_src),
    .used      (id_use),
    .id_branch (id_branch),
    .id_taken  (id_taken),
    .ex_rd     (ex_rd),
    .ex_wen    (ex_wen),
    .ex_load   (ex_load),
    .mem_rd    (mem_rd),
    .mem_wen   (mem_wen),
    .mem_load  (mem_load),
    .load_use  (load_use_evt),
    .br_wait   (br_wait_evt),
    .stall     (stall_evt),
    .flush     (flush_evt)
  );

  assign ex_sel_a     = ex_sel_v[0];
  assign ex_sel_b     = ex_sel_v[1];
  assign id_sel_a     = id_sel_v[0];
  assign id_sel_b     = id_sel_v[1];
  assign stall_fetch  = stall_evt;
  assign stall_decode = stall_evt;
  assign bubble_ex    = stall_evt;
  assign flush_fetch  = flush_evt;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] id_rs,
  input logic          id_branch,
  input logic          id_taken,
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rt,
  input logic          ex_load,
  input logic          ex_wen,
  input logic          mem_load,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b,
  input logic          id_sel_a,
  input logic          id_sel_b,
  input logic          stall_fetch,
  input logic          stall_decode,
  input logic          bubble_ex,
  input logic          flush_fetch,
  input logic          load_use_evt,
  input logic          br_wait_evt
);
  always_comb begin
    p_stall_fanout_r4: assert (stall_fetch == stall_decode && stall_decode == bubble_ex)
      else $error("stall outputs disagree");
    p_load_use_cause_r4: assert (!load_use_evt || (ex_load && ex_wen))
      else $error("load-use event without a load in execute");
    p_zero_quiet_r3: assert ((ex_rs != '0 || ex_sel_a == 2'd0) &&
                             (ex_rt != '0 || ex_sel_b == 2'd0) &&
                             (id_rs != '0 || !id_sel_a))
      else $error("register 0 was forwarded");
    p_branch_wait_r5: assert (!br_wait_evt || id_branch)
      else $error("branch wait without a branch");
    p_no_load_fwd_r7: assert (!(id_sel_a || id_sel_b) || !mem_load)
      else $error("load forwarded to comparator");
    p_flush_yields_r9: assert (!(flush_fetch && stall_fetch))
      else $error("flush during stall");
    p_flush_cause_r9: assert (!flush_fetch || (id_branch && id_taken))
      else $error("flush without taken branch");
  end
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) u_chk (
  .id_rs        (id_rs),
  .id_branch    (id_branch),
  .id_taken     (id_taken),
  .ex_rs        (ex_rs),
  .ex_rt        (ex_rt),
  .ex_load      (ex_load),
  .ex_wen       (ex_wen),
  .mem_load     (mem_load),
  .ex_sel_a     (ex_sel_a),
  .ex_sel_b     (ex_sel_b),
  .id_sel_a     (id_sel_a),
  .id_sel_b     (id_sel_b),
  .stall_fetch  (stall_fetch),
  .stall_decode (stall_decode),
  .bubble_ex    (bubble_ex),
  .flush_fetch  (flush_fetch),
  .load_use_evt (load_use_evt),
  .br_wait_evt  (br_wait_evt)
);

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;
  localparam int unsigned AW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs = '0, id_rt = '0, ex_rs = '0, ex_rt = '0;
  logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic id_use_rs = 0, id_use_rt = 0, id_branch = 0, id_taken = 0;
  logic ex_use_rs = 0, ex_use_rt = 0, ex_wen = 0, ex_load = 0;
  logic mem_wen = 0, mem_load = 0, wb_wen = 0;
  logic [1:0] ex_sel_a, ex_sel_b;
  logic id_sel_a, id_sel_b, stall_fetch, stall_decode, bubble_ex, flush_fetch;

  int n_vec = 0;
  int n_bad = 0;

  hazard_unit #(.AW(AW)) uut (.*);

  // Bench model, written per consumer distance.
  function automatic logic [1:0] m_ex(input logic [AW-1:0] s, input logic u);
    if (!u || s == 0) return 2'd0;
    if (mem_wen && mem_rd == s) return 2'd2;
    if (wb_wen && wb_rd == s) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic m_id(input logic [AW-1:0] s, input logic u);
    return u && s != 0 && mem_wen && !mem_load && mem_rd == s;
  endfunction

  function automatic logic m_wait(input logic [AW-1:0] s, input logic u);
    if (!u || s == 0) return 1'b0;
    if (ex_wen && ex_rd == s && (ex_load || id_branch)) return 1'b1;
    if (id_branch && mem_wen && mem_load && mem_rd == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clear();
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
    {id_use_rs, id_use_rt, id_branch, id_taken, ex_use_rs, ex_use_rt} = '0;
    {ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp,
                     inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      bad = 1'b1;
    end
  endtask

  // Inputs are set just after a rising edge; outputs are sampled at the falling edge.
  task automatic run(input string tag);
    logic st;
    bit bad;
    bad = 1'b0;
    @(negedge clk);
    st = m_wait(id_rs, id_use_rs) || m_wait(id_rt, id_use_rt);
    cmp({tag, " R1"}, "ex_sel_a", ex_sel_a, m_ex(ex_rs, ex_use_rs), bad);
    cmp({tag, " R1"}, "ex_sel_b", ex_sel_b, m_ex(ex_rt, ex_use_rt), bad);
    cmp({tag, " R7"}, "id_sel_a", id_sel_a, m_id(id_rs, id_use_rs), bad);
    cmp({tag, " R7"}, "id_sel_b", id_sel_b, m_id(id_rt, id_use_rt), bad);
    cmp({tag, " R4"}, "stall_fetch", stall_fetch, st, bad);
    cmp({tag, " R4"}, "stall_decode", stall_decode, st, bad);
    cmp({tag, " R4"}, "bubble_ex", bubble_ex, st, bad);
    cmp({tag, " R9"}, "flush_fetch", flush_fetch, id_branch && id_taken && !st, bad);
    n_vec++;
    if (bad) n_bad++;
  endtask

  task automatic step();
    @(posedge clk);
    clear();
  endtask

  initial begin
    #(5.0 * 200000);
    $display("FAIL watchdog: got timeout expected completion");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R3: idle pipeline, everything quiet
    step(); run("R3 idle");
    // R1: memory-stage writer feeds ALU input A
    step(); ex_rs = 5; ex_use_rs = 1; mem_rd = 5; mem_wen = 1; run("R1 mem fwd");
    // R2: writeback writer feeds ALU input B
    step(); ex_rt = 6; ex_use_rt = 1; wb_rd = 6; wb_wen = 1; run("R2 wb fwd");
    // R2: both late stages match, younger wins
    step(); ex_rt = 6; ex_use_rt = 1; wb_rd = 6; wb_wen = 1; mem_rd = 6; mem_wen = 1;
    run("R2 younger wins");
    // R3: register 0 everywhere
    step(); ex_rs = 0; ex_use_rs = 1; mem_wen = 1; id_use_rs = 1; ex_wen = 1; ex_load = 1;
    id_branch = 1; id_taken = 1; run("R3 zero reg");
    // R4: load-use for a plain consumer
    step(); id_rs = 7; id_use_rs = 1; ex_rd = 7; ex_wen = 1; ex_load = 1; run("R4 load use");
    // R10: ALU producer to ALU consumer, no stall
    step(); id_rt = 7; id_use_rt = 1; ex_rd = 7; ex_wen = 1; run("R10 alu no stall");
    // R11: unused source ignores a matching load
    step(); id_rs = 7; id_use_rs = 0; ex_rd = 7; ex_wen = 1; ex_load = 1; run("R11 unused src");
    // R5 then R7: ALU producer ahead of a taken branch
    step(); id_branch = 1; id_taken = 1; id_rs = 3; id_use_rs = 1; ex_rd = 3; ex_wen = 1;
    run("R5 branch alu in ex");
    step(); id_branch = 1; id_taken = 1; id_rs = 3; id_use_rs = 1; mem_rd = 3; mem_wen = 1;
    run("R7 branch fwd from mem");
    // R6: load ahead of a branch, walked through three stages
    step(); id_branch = 1; id_taken = 1; id_rt = 4; id_use_rt = 1; ex_rd = 4; ex_wen = 1;
    ex_load = 1; run("R6 load in ex");
    step(); id_branch = 1; id_taken = 1; id_rt = 4; id_use_rt = 1; mem_rd = 4; mem_wen = 1;
    mem_load = 1; run("R6 load in mem");
    // R8: writeback writer, no select, no stall, flush proceeds
    step(); id_branch = 1; id_taken = 1; id_rt = 4; id_use_rt = 1; wb_rd = 4; wb_wen = 1;
    run("R8 wb no fwd");
    // R9: not-taken branch never flushes
    step(); id_branch = 1; id_taken = 0; run("R9 not taken");
    // Random stage contents over a small register set
    for (int i = 0; i < 4000; i++) begin
      step();
      id_rs = AW'($urandom_range(0, 3)); id_rt = AW'($urandom_range(0, 3));
      ex_rs = AW'($urandom_range(0, 3)); ex_rt = AW'($urandom_range(0, 3));
      ex_rd = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      wb_rd = AW'($urandom_range(0, 3));
      {id_use_rs, id_use_rt, id_branch, id_taken} = 4'($urandom);
      {ex_use_rs, ex_use_rt, ex_wen, mem_wen, wb_wen} = 5'($urandom);
      ex_load = ex_wen & 1'($urandom);
      mem_load = mem_wen & 1'($urandom);
      run("RND");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule